// File: doc/BRIEF.md
# Zero-Turnaround Flow-Through Synchronous SRAM

This block is a single-port synchronous SRAM whose commands are registered on the rising clock edge and whose read data flows straight from the storage array within the cycle that follows the command edge. Write data trails its command by one edge, and that edge is also the next command edge. A read, a write or a deselect can therefore be issued on every clock, in any mix, with no idle cycle when the bus direction turns around.

A load command names a full address. Up to three further advance commands then step the two low address bits in linear or XOR (interleaved) order, and the read or write type chosen at the load is kept. Each 9-bit lane (8 data bits plus a parity bit) has its own active-low write select. Three chip selects gate new accesses. A clock-run input freezes the whole block when it is high. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output. Written words first wait in a one-entry pending register, and reads that hit it are merged lane by lane, so the array never needs a read-before-write port.

Top module: `zbt_ft_sram`

## Requirements
- R1: While and after a synchronous reset the block is deselected and `rdata_en` is 0; `rdata` is 0 whenever `rdata_en` is 0.
- R2: A load edge (`run_n`=0, `cs_a_n`=0, `cs_b`=1, `cs_c_n`=0, `burst_step`=0) with `wr_n`=1 starts a read. In the cycle after that edge, `rdata` holds the word at `addr` and `rdata_en`=1 if `drive_n`=0.
- R3: For a write started at a load or advance edge, `wdata` and `lane_wr_n` are sampled at the next edge. Lane l is `wdata[9l+8:9l]`, bit 9l+8 being the parity bit. A lane whose select is 0 is written and every other lane keeps its old value.
- R4: Accesses run back to back. A read commanded at the edge that captures a write's data returns the newly written lanes.
- R5: An edge with `run_n`=1 is ignored. Address, burst state, access type and any pending write are all held, nothing is written, and `rdata`/`rdata_en` stay unchanged while `drive_n` is unchanged.
- R6: With `order_xor`=0 at the load edge, advance edges visit the low two address bits as start+1, start+2, start+3, modulo 4.
- R7: With `order_xor`=1 at the load edge, the low two bits at beat k are start XOR k (start 01 gives 01, 00, 11, 10).
- R8: An advance edge (`burst_step`=1) ignores the chip selects and `wr_n`. The burst keeps the type latched at the load, and after the fourth beat it wraps to the start address.
- R9: `rdata_en` is 0 during the cycle after a write command edge, regardless of `drive_n`, and it is 0 whenever `drive_n`=1.
- R10: A load edge with any chip select inactive deselects the block, and `rdata_en` is 0 in the cycle that follows. An advance edge while deselected keeps the block deselected.
- R11: A write whose four lane selects are all 1 leaves the addressed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Low: edge is acted upon; high: edge ignored |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| burst_step | input | 1 | High: advance burst; low: load new command |
| wr_n | input | 1 | Access type at load: 0 write, 1 read |
| order_xor | input | 1 | Burst order at load: 0 linear, 1 XOR |
| addr | input | ADDR_W | Word address |
| lane_wr_n | input | LANES | Per-lane write selects for the data beat, active low |
| drive_n | input | 1 | Output drive request, active low, not registered |
| wdata | input | LANES*LANE_W | Write data for the beat commanded at the previous edge |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdata_en | output | 1 | High when the block drives read data |

## Verification
Read data belongs to the cycle just after its command edge. Write data and lane selects belong to the edge after their command edge, and a read commanded at that edge must already see them. The bench drives one set of inputs per edge and applies the same edge to a behavioural word array and burst model. It then compares `rdata` and `rdata_en` 1 ns after the edge, before any input changes, so each expected value is the one due for that exact cycle. Stalls, burst wraps, deselects and partial lane writes are placed between commands to move these due points around, and a random phase mixes all of them.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  // Low address bits for beat number `beat` of a burst that started at `base`.
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] beat,
                                          input burst_order_e ord);
    if (ord == ORD_XOR) return base ^ beat;
    return base + beat;
  endfunction

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              sel,
  input  logic              step,
  input  logic              wr,
  input  logic              order,
  input  logic [ADDR_W-1:0] addr,
  output logic              act_valid,
  output logic              act_wr,
  output logic [ADDR_W-1:0] act_addr
);

  logic [1:0]   base_q;
  logic [1:0]   beat_q;
  burst_order_e ord_q;
  logic [1:0]   beat_nx;

  assign beat_nx = beat_q + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_valid <= 1'b0;
      act_wr    <= 1'b0;
      act_addr  <= '0;
      base_q    <= '0;
      beat_q    <= '0;
      ord_q     <= ORD_LINEAR;
    end else if (run) begin
      if (!step) begin
        act_valid <= sel;
        act_wr    <= wr;
        act_addr  <= addr;
        base_q    <= addr[1:0];
        beat_q    <= '0;
        ord_q     <= burst_order_e'(order);
      end else if (act_valid) begin
        beat_q        <= beat_nx;
        act_addr[1:0] <= beat_low(base_q, beat_nx, ord_q);
      end
    end
  end

endmodule

// File: rtl/zbt_wbuf.sv
module zbt_wbuf #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              capture,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [WORD_W-1:0] cap_data,
  input  logic [LANES-1:0]  cap_lanes,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] arr_word,
  output logic [LANES-1:0]  commit_we,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [WORD_W-1:0] commit_data,
  output logic [WORD_W-1:0] merged
);

  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [WORD_W-1:0] pend_data;
  logic [LANES-1:0]  pend_lanes;
  logic              hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v     <= 1'b0;
      pend_addr  <= '0;
      pend_data  <= '0;
      pend_lanes <= '0;
    end else if (run) begin
      pend_v <= capture;
      if (capture) begin
        pend_addr  <= cap_addr;
        pend_data  <= cap_data;
        pend_lanes <= cap_lanes;
      end
    end
  end

  // The held word drains into the array on the next acted-upon edge.
  assign commit_we   = (run && pend_v) ? pend_lanes : '0;
  assign commit_addr = pend_addr;
  assign commit_data = pend_data;
  assign hit         = pend_v && (pend_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] = (hit && pend_lanes[l]) ?
                                        pend_data[l*LANE_W +: LANE_W] :
                                        arr_word[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int WORD_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wword,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rword
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[l]) mem[waddr] <= wword[l*LANE_W +: LANE_W];
    end

    assign rword[l*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/zbt_ft_sram.sv
module zbt_ft_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      run_n,
  input  logic                      cs_a_n,
  input  logic                      cs_b,
  input  logic                      cs_c_n,
  input  logic                      burst_step,
  input  logic                      wr_n,
  input  logic                      order_xor,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES-1:0]          lane_wr_n,
  input  logic                      drive_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_en
);

  localparam int WORD_W = LANES * LANE_W;

  logic              run;
  logic              sel;
  logic              act_valid;
  logic              act_wr;
  logic [ADDR_W-1:0] act_addr;
  logic [LANES-1:0]  commit_we;
  logic [ADDR_W-1:0] commit_addr;
  logic [WORD_W-1:0] commit_data;
  logic [WORD_W-1:0] arr_word;
  logic [WORD_W-1:0] merged;

  assign run = !run_n;
  assign sel = !cs_a_n && cs_b && !cs_c_n;

  zbt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .sel      (sel),
    .step     (burst_step),
    .wr       (!wr_n),
    .order    (order_xor),
    .addr     (addr),
    .act_valid(act_valid),
    .act_wr   (act_wr),
    .act_addr (act_addr)
  );

  zbt_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .capture    (act_valid && act_wr),
    .cap_addr   (act_addr),
    .cap_data   (wdata),
    .cap_lanes  (~lane_wr_n),
    .rd_addr    (act_addr),
    .arr_word   (arr_word),
    .commit_we  (commit_we),
    .commit_addr(commit_addr),
    .commit_data(commit_data),
    .merged     (merged)
  );

  zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk  (clk),
    .we   (commit_we),
    .waddr(commit_addr),
    .wword(commit_data),
    .raddr(act_addr),
    .rword(arr_word)
  );

  assign rdata_en = act_valid && !act_wr && !drive_n;
  assign rdata    = rdata_en ? merged : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int WORD_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              run_n,
  input logic              cs_a_n,
  input logic              cs_b,
  input logic              cs_c_n,
  input logic              burst_step,
  input logic              wr_n,
  input logic              drive_n,
  input logic [WORD_W-1:0] rdata,
  input logic              rdata_en,
  input logic              act_valid,
  input logic              act_wr
);

  logic load_sel;
  logic load_desel;
  assign load_sel   = !run_n && !burst_step && !cs_a_n && cs_b && !cs_c_n;
  assign load_desel = !run_n && !burst_step && (cs_a_n || !cs_b || cs_c_n);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !rdata_en);  // R1

  AST_WRITE_PHASE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (load_sel && !wr_n) |=> !rdata_en);  // R9

  AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (rst)
    drive_n |-> !rdata_en);  // R9

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    load_desel |=> !rdata_en);  // R10

  AST_CONT_DESEL: assert property (@(posedge clk) disable iff (rst)
    (!run_n && burst_step && !act_valid) |=> !act_valid);  // R10

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run_n) && $stable(drive_n)) |->
      ($stable(rdata) && $stable(rdata_en)));  // R5

  AST_BURST_TYPE: assert property (@(posedge clk) disable iff (rst)
    (!run_n && burst_step && act_valid) |=> $stable(act_wr));  // R8

endmodule

bind zbt_ft_sram zbt_sram_chk #(.WORD_W(LANES*LANE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run_n     (run_n),
  .cs_a_n    (cs_a_n),
  .cs_b      (cs_b),
  .cs_c_n    (cs_c_n),
  .burst_step(burst_step),
  .wr_n      (wr_n),
  .drive_n   (drive_n),
  .rdata     (rdata),
  .rdata_en  (rdata_en),
  .act_valid (act_valid),
  .act_wr    (act_wr)
);

// File: tb/zbt_ft_sram_tb.sv
`timescale 1ns/100ps
module zbt_ft_sram_tb;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int WW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_n = 1'b0;
  logic          cs_a_n = 1'b1;
  logic          cs_b = 1'b0;
  logic          cs_c_n = 1'b1;
  logic          burst_step = 1'b0;
  logic          wr_n = 1'b1;
  logic          order_xor = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] lane_wr_n = '1;
  logic          drive_n = 1'b1;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          rdata_en;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  // behavioural reference
  logic [WW-1:0] m_mem [DEPTH];
  bit            m_valid = 0;
  bit            m_wr = 0;
  int            m_addr = 0;
  int            m_base = 0;
  int            m_beat = 0;
  bit            m_ord = 0;

  zbt_ft_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .run_n(run_n), .cs_a_n(cs_a_n), .cs_b(cs_b),
    .cs_c_n(cs_c_n), .burst_step(burst_step), .wr_n(wr_n),
    .order_xor(order_xor), .addr(addr), .lane_wr_n(lane_wr_n),
    .drive_n(drive_n), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_err++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [WW-1:0] rnd36();
    logic [63:0] t;
    t = {$urandom, $urandom};
    return t[WW-1:0];
  endfunction

  task automatic model_edge();
    if (!run_n) begin
      if (m_valid && m_wr)
        for (int l = 0; l < NL; l++)
          if (!lane_wr_n[l]) m_mem[m_addr][l*LW +: LW] = wdata[l*LW +: LW];
      if (!burst_step) begin
        if (!cs_a_n && cs_b && !cs_c_n) begin
          m_valid = 1; m_wr = !wr_n; m_addr = int'(addr);
          m_base = m_addr % 4; m_beat = 0; m_ord = order_xor;
        end else begin
          m_valid = 0;
        end
      end else if (m_valid) begin
        m_beat = (m_beat + 1) % 4;
        m_addr = (m_addr / 4) * 4 +
                 (m_ord ? (m_base ^ m_beat) : ((m_base + m_beat) % 4));
      end
    end
  endtask

  task automatic check(input string tag);
    logic          e_en;
    logic [WW-1:0] e_d;
    e_en = m_valid && !m_wr && !drive_n;
    e_d  = e_en ? m_mem[m_addr] : '0;
    n_chk++;
    if (rdata_en !== e_en || rdata !== e_d) begin
      n_err++;
      $display("FAIL %s t=%0t actual en=%b data=%h expected en=%b data=%h",
               tag, $time, rdata_en, rdata, e_en, e_d);
    end
  endtask

  task automatic go(input logic rn, input logic a, input logic b, input logic c,
                    input logic stp, input logic w, input logic [NL-1:0] ln,
                    input logic [AW-1:0] ad, input logic ord, input logic dn,
                    input logic [WW-1:0] wd, input string tag);
    run_n = rn; cs_a_n = a; cs_b = b; cs_c_n = c; burst_step = stp;
    wr_n = w; lane_wr_n = ln; addr = ad; order_xor = ord; drive_n = dn;
    wdata = wd;
    @(posedge clk);
    model_edge();
    #1;
    check(tag);
  endtask

  // load command; ln/wd are the data beat of the previous write, if any
  task automatic ld(input logic w, input logic [AW-1:0] ad, input logic ord,
                    input logic dn, input logic [NL-1:0] ln,
                    input logic [WW-1:0] wd, input string tag);
    go(0, 0, 1, 0, 0, w, ln, ad, ord, dn, wd, tag);
  endtask

  task automatic adv(input logic dn, input logic [NL-1:0] ln,
                     input logic [WW-1:0] wd, input string tag);
    go(0, $urandom % 2, $urandom % 2, $urandom % 2, 1, $urandom % 2, ln,
       AW'($urandom), $urandom % 2, dn, wd, tag);
  endtask

  task automatic dsl(input logic [NL-1:0] ln, input logic [WW-1:0] wd,
                     input string tag);
    go(0, 1, 1, 0, 0, 1, ln, '0, 0, 0, wd, tag);
  endtask

  initial begin
    // R1: reset state
    repeat (3) begin
      @(posedge clk); #1;
      n_chk++;
      if (rdata_en !== 1'b0 || rdata !== '0) begin
        n_err++;
        $display("FAIL R1 actual en=%b data=%h expected en=0 data=0", rdata_en, rdata);
      end
    end
    rst = 1'b0;
    dsl('1, '0, "R1");

    // R6/R3: fill the array with linear write bursts, back to back
    for (int b = 0; b < DEPTH / 4; b++) begin
      ld(0, AW'(b * 4), 0, 0, '0, rnd36(), "R3");
      repeat (3) adv(0, '0, rnd36(), "R6");
    end
    dsl('0, rnd36(), "R3");

    // R2: single reads, output driven
    for (int i = 0; i < 6; i++) ld(1, AW'($urandom), 0, 0, '1, rnd36(), "R2");
    // R9: drive request off during reads
    ld(1, 6'd5, 0, 1, '1, rnd36(), "R9");
    ld(1, 6'd6, 0, 0, '1, rnd36(), "R9");

    // R6: linear read burst from low bits 11
    ld(1, 6'd23, 0, 0, '1, rnd36(), "R6");
    repeat (3) adv(0, '1, rnd36(), "R6");
    // R7: XOR read burst from low bits 01
    ld(1, 6'd33, 1, 0, '1, rnd36(), "R7");
    repeat (3) adv(0, '1, rnd36(), "R7");
    // R8: six-beat burst wraps, selects and type ignored
    ld(1, 6'd42, 1, 0, '1, rnd36(), "R8");
    repeat (6) adv(0, '1, rnd36(), "R8");
    ld(1, 6'd13, 0, 0, '1, rnd36(), "R8");
    repeat (5) adv(0, '1, rnd36(), "R8");

    // R4: write then immediate read of the same word, read-write-read
    ld(0, 6'd9, 0, 0, '1, rnd36(), "R4");
    ld(1, 6'd9, 0, 0, '0, rnd36(), "R4");
    ld(0, 6'd10, 0, 0, '1, rnd36(), "R4");
    ld(1, 6'd9, 0, 0, '0, rnd36(), "R4");
    ld(1, 6'd10, 0, 0, '1, rnd36(), "R4");

    // R3: partial lane writes
    ld(0, 6'd17, 0, 0, '1, rnd36(), "R3");
    ld(0, 6'd18, 0, 0, 4'b0101, rnd36(), "R3");
    ld(1, 6'd17, 0, 0, 4'b1110, rnd36(), "R3");
    ld(1, 6'd18, 0, 0, '1, rnd36(), "R3");
    // R11: write with no lanes selected
    ld(0, 6'd19, 0, 0, '1, rnd36(), "R11");
    ld(1, 6'd19, 0, 0, 4'b1111, rnd36(), "R11");
    ld(1, 6'd19, 0, 0, '1, rnd36(), "R11");

    // R5: stall inside a write data phase and inside a read
    ld(0, 6'd25, 0, 0, '1, rnd36(), "R5");
    go(1, 1, 0, 1, 0, 1, '0, 6'd3, 0, 0, rnd36(), "R5");
    go(1, 0, 1, 0, 0, 0, '0, 6'd4, 1, 0, rnd36(), "R5");
    ld(1, 6'd25, 0, 0, '0, rnd36(), "R5");
    go(1, 0, 1, 0, 0, 0, '0, 6'd7, 0, 0, rnd36(), "R5");
    go(1, 0, 1, 0, 1, 0, '0, 6'd8, 0, 0, rnd36(), "R5");
    adv(0, '1, rnd36(), "R5");

    // R10: deselect and continued deselect, then reload
    dsl('1, rnd36(), "R10");
    go(0, 0, 1, 0, 1, 1, '1, 6'd2, 0, 0, rnd36(), "R10");
    go(0, 0, 0, 0, 0, 1, '1, 6'd2, 0, 0, rnd36(), "R10");
    go(0, 0, 1, 1, 0, 1, '1, 6'd2, 0, 0, rnd36(), "R10");
    ld(1, 6'd2, 0, 0, '1, rnd36(), "R10");

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic s;
      s = ($urandom % 6) != 0;
      go(($urandom % 5) == 0, s ? 1'b0 : 1'($urandom), s ? 1'b1 : 1'b0,
         s ? 1'b0 : 1'($urandom), ($urandom % 3) == 0, 1'($urandom),
         NL'($urandom), AW'($urandom), 1'($urandom), ($urandom % 8) == 0,
         rnd36(), "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule